// File: doc/BRIEF.md
# Half-Word Arithmetic Shifter with Signed Count

This block takes one 16-bit half of a 32-bit source word and shifts it arithmetically. The shift amount and its direction come from a signed count, which is read from the lower half of a second 32-bit word. A negative count shifts right by its magnitude and fills the vacated bits with the sign. A positive count shifts left and fills with zeros. A zero count passes the operand through unchanged.

The 16-bit result replaces either the upper or the lower half of a 32-bit destination word. The other half keeps the value supplied on the old-destination input. The source half and the destination half are chosen independently. The merged word is captured in a register on a clock edge when the write enable is high, so a datapath can use the same register as both source and destination. The operand is read from the pre-write value.

Top module: `hw_ashift_merge`

## Requirements
- R1: A negative count of magnitude 1 to 15 shifts the operand right arithmetically by that magnitude, and copies of operand bit 15 fill the vacated upper bits (0x8001 by -1 gives 0xC000).
- R2: A count of zero passes the selected 16-bit operand to the destination half unchanged.
- R3: A negative count of magnitude 15 or more gives a full sign fill: 0xFFFF for an operand with bit 15 set, and 0x0000 otherwise. This includes -16 and the most negative count 0x8000.
- R4: The count is bits 15:0 of `cnt_word`, read as two's complement. Bits 31:16 of `cnt_word` have no effect on the result.
- R5: `src_hi_sel`=1 selects `src_word[31:16]` as the operand and 0 selects `src_word[15:0]`. This choice does not depend on `dst_hi_sel`.
- R6: `dst_hi_sel`=1 writes the result into bits 31:16 and 0 writes it into bits 15:0. The other 16 bits equal the matching bits of `dst_old`.
- R7: A positive count below 16 shifts the operand left and zeros fill the low bits. A positive count of 16 or more gives 0x0000.
- R8: `dst_word` updates on the rising clock edge only when `wr_en`=1. Otherwise it holds its value.
- R9: `rst_n`=0 at a rising edge clears `dst_word` to 0 (synchronous, active low), and this overrides `wr_en`.
- R10: When `src_word` and `dst_old` carry the same register value, the operand is taken from that pre-write value (0x00009001, lower half shifted by -15 into the upper half, gives 0xFFFF9001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Capture the merged word at this edge |
| src_word | input | 32 | Word holding the operand |
| src_hi_sel | input | 1 | Operand half: 1 upper, 0 lower |
| cnt_word | input | 32 | Count word; bits 15:0 are the signed count |
| dst_old | input | 32 | Previous destination contents |
| dst_hi_sel | input | 1 | Destination half: 1 upper, 0 lower |
| dst_word | output | 32 | Registered merged destination word |

## Verification
The hardest cases sit at the edges of the count range. The first is a magnitude of exactly 15 or 16 in either direction. The second is the most negative count 0x8000, whose negation overflows back to itself. The stimulus table sets these counts directly on the lower half of the count word. It pairs them with operands of both signs, and some entries put nonzero bits in the upper half of the count word. Other entries make the source and old-destination words identical, to cover the same-register case.

// File: rtl/hw_ashift_pkg.sv
// Package: shared constants and types for the half-word shifter.
// Assumes the half width is a power of two.
package hw_ashift_pkg;
    localparam int HALF_W_DEF = 16;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;
endpackage

// File: rtl/hw_half_pick.sv
// Selects one half of a word as the shift operand.
// Assumes the word is exactly two halves wide.
module hw_half_pick #(
    parameter int HALF_W = hw_ashift_pkg::HALF_W_DEF
) (
    input  logic [2*HALF_W-1:0] word_in,
    input  logic                hi_sel,
    output logic [HALF_W-1:0]   half_out
);
    import hw_ashift_pkg::*;

    // Purpose: multiplex the upper or lower half onto the operand bus.
    always_comb begin
        if (half_sel_e'(hi_sel) == HALF_HI) half_out = word_in[2*HALF_W-1:HALF_W];
        else                                half_out = word_in[HALF_W-1:0];
    end
endmodule

// File: rtl/hw_signed_shift.sv
// Arithmetic shift of a half-word by a signed count of the same width.
// A negative count shifts right with sign fill, a positive count shifts left
// with zero fill, and a magnitude of HALF_W or more saturates.
// Assumes HALF_W is a power of two.
module hw_signed_shift #(
    parameter int HALF_W = hw_ashift_pkg::HALF_W_DEF
) (
    input  logic [HALF_W-1:0] op,
    input  logic [HALF_W-1:0] cnt,
    output logic [HALF_W-1:0] res
);
    localparam int SHW = $clog2(HALF_W);

    logic              neg;
    logic              sgn;
    logic [HALF_W-1:0] mag;
    logic              big;
    logic [SHW-1:0]    amt;
    logic [HALF_W-1:0] rs [SHW+1];
    logic [HALF_W-1:0] ls [SHW+1];

    // Purpose: split the count into direction, magnitude and saturation flag.
    always_comb begin
        neg = cnt[HALF_W-1];
        sgn = op[HALF_W-1];
        mag = neg ? (~cnt + 1'b1) : cnt;
        big = |mag[HALF_W-1:SHW];
        amt = mag[SHW-1:0];
    end

    assign rs[0] = op;
    assign ls[0] = op;

    // Logarithmic barrel stages, one per bit of the shift amount.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign rs[k+1] = amt[k] ? {{STEP{sgn}}, rs[k][HALF_W-1:STEP]} : rs[k];
        assign ls[k+1] = amt[k] ? {ls[k][HALF_W-1-STEP:0], {STEP{1'b0}}} : ls[k];
    end

    // Purpose: choose the direction and apply saturation.
    always_comb begin
        if (neg) res = big ? {HALF_W{sgn}} : rs[SHW];
        else     res = big ? '0 : ls[SHW];
    end
endmodule

// File: rtl/hw_half_merge.sv
// Replaces one half of the old destination word with the shift result.
// Assumes the word is exactly two halves wide.
module hw_half_merge #(
    parameter int HALF_W = hw_ashift_pkg::HALF_W_DEF
) (
    input  logic [2*HALF_W-1:0] old_word,
    input  logic [HALF_W-1:0]   new_half,
    input  logic                hi_sel,
    output logic [2*HALF_W-1:0] merged
);
    import hw_ashift_pkg::*;

    // Purpose: keep the unselected half and insert the result into the other.
    always_comb begin
        if (half_sel_e'(hi_sel) == HALF_HI) merged = {new_half, old_word[HALF_W-1:0]};
        else                                merged = {old_word[2*HALF_W-1:HALF_W], new_half};
    end
endmodule

// File: rtl/hw_ashift_merge.sv
// Top level: picks an operand half, shifts it by the signed lower half of the
// count word, merges the result into one half of the old destination word, and
// registers it under write enable. Synchronous active-low reset clears it.
module hw_ashift_merge #(
    parameter int HALF_W = hw_ashift_pkg::HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2*HALF_W-1:0] src_word,
    input  logic                src_hi_sel,
    input  logic [2*HALF_W-1:0] cnt_word,
    input  logic [2*HALF_W-1:0] dst_old,
    input  logic                dst_hi_sel,
    output logic [2*HALF_W-1:0] dst_word
);
    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] operand;
    logic [HALF_W-1:0] shifted;
    logic [WORD_W-1:0] merged;

    hw_half_pick #(.HALF_W(HALF_W)) u_pick (
        .word_in  (src_word),
        .hi_sel   (src_hi_sel),
        .half_out (operand)
    );

    hw_signed_shift #(.HALF_W(HALF_W)) u_shift (
        .op  (operand),
        .cnt (cnt_word[HALF_W-1:0]),
        .res (shifted)
    );

    hw_half_merge #(.HALF_W(HALF_W)) u_merge (
        .old_word (dst_old),
        .new_half (shifted),
        .hi_sel   (dst_hi_sel),
        .merged   (merged)
    );

    // Purpose: destination register with reset and write enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     dst_word <= '0;
        else if (wr_en) dst_word <= merged;
    end
endmodule

// File: rtl/hw_ashift_merge_chk.sv
// Checker for hw_ashift_merge, attached by bind. It observes ports only.
module hw_ashift_merge_chk #(
    parameter int HALF_W = hw_ashift_pkg::HALF_W_DEF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2*HALF_W-1:0] src_word,
    input logic                src_hi_sel,
    input logic [2*HALF_W-1:0] cnt_word,
    input logic [2*HALF_W-1:0] dst_old,
    input logic                dst_hi_sel,
    input logic [2*HALF_W-1:0] dst_word
);
    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] pick_op;
    logic [HALF_W-1:0] low_cnt;

    // Purpose: operand and count as seen at the ports.
    always_comb begin
        pick_op = src_hi_sel ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
        low_cnt = cnt_word[HALF_W-1:0];
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> dst_word == '0);

    assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dst_word));

    assert_keep_low_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dst_hi_sel) |=> dst_word[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]));

    assert_keep_high_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dst_hi_sel) |=> dst_word[WORD_W-1:HALF_W] == $past(dst_old[WORD_W-1:HALF_W]));

    assert_zero_count_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dst_hi_sel && low_cnt == '0) |=> dst_word[WORD_W-1:HALF_W] == $past(pick_op));

    assert_neg_sat_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dst_hi_sel && $signed(low_cnt) <= -HALF_W && pick_op[HALF_W-1])
        |=> dst_word[HALF_W-1:0] == '1);
endmodule

bind hw_ashift_merge hw_ashift_merge_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .src_word   (src_word),
    .src_hi_sel (src_hi_sel),
    .cnt_word   (cnt_word),
    .dst_old    (dst_old),
    .dst_hi_sel (dst_hi_sel),
    .dst_word   (dst_word)
);

// File: tb/hw_ashift_merge_test.sv
`timescale 1ns/1ps
module hw_ashift_merge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] src_word = '0;
    logic        src_hi_sel = 1'b0;
    logic [31:0] cnt_word = '0;
    logic [31:0] dst_old = '0;
    logic        dst_hi_sel = 1'b0;
    logic [31:0] dst_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hw_ashift_merge uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .src_word(src_word),
        .src_hi_sel(src_hi_sel), .cnt_word(cnt_word), .dst_old(dst_old),
        .dst_hi_sel(dst_hi_sel), .dst_word(dst_word)
    );

    // Fields: src[129:98] shi[97] cnt[96:65] old[64:33] dhi[32] exp[31:0]
    localparam int NV = 14;
    localparam logic [129:0] VEC [NV] = '{
        {32'h00008001, 1'b0, 32'h0000FFFF, 32'h12340000, 1'b0, 32'h1234C000}, // R1 R6
        {32'h00008003, 1'b0, 32'hABCDFFFF, 32'h00000000, 1'b0, 32'h0000C001}, // R1 R4
        {32'h80010000, 1'b1, 32'h00000000, 32'h80010000, 1'b0, 32'h80018001}, // R2 R5
        {32'hA0010000, 1'b1, 32'h0000FFF1, 32'hA0010000, 1'b0, 32'hA001FFFF}, // R3
        {32'hB0010001, 1'b1, 32'h5555FFF0, 32'hB0010001, 1'b0, 32'hB001FFFF}, // R3 R4
        {32'h00009001, 1'b0, 32'h0000FFF1, 32'h00009001, 1'b1, 32'hFFFF9001}, // R10 R5
        {32'h80010000, 1'b1, 32'h0000FFFF, 32'h80010000, 1'b1, 32'hC0000000}, // R1 R6
        {32'h00000003, 1'b0, 32'h00000004, 32'hFFFFFFFF, 1'b1, 32'h0030FFFF}, // R7
        {32'h0000FFFF, 1'b0, 32'h00000010, 32'h11112222, 1'b1, 32'h00002222}, // R7
        {32'h7FFF0000, 1'b1, 32'h0000FFE0, 32'h00000000, 1'b0, 32'h00000000}, // R3
        {32'h12345678, 1'b0, 32'h00000003, 32'hAAAA5555, 1'b0, 32'hAAAAB3C0}, // R7
        {32'h40000000, 1'b1, 32'h0000FFFE, 32'h00007777, 1'b1, 32'h10007777}, // R1
        {32'h00008000, 1'b0, 32'h00008000, 32'h00000000, 1'b0, 32'h0000FFFF}, // R3
        {32'h00000001, 1'b0, 32'hFFFF000F, 32'h00000000, 1'b0, 32'h00008000}  // R7 R4
    };

    task automatic check(input string tag, input logic [31:0] exp);
        total++;
        if (dst_word !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, dst_word, exp);
        end
    endtask

    task automatic drive(input logic [129:0] v, input logic we);
        @(negedge clk);
        src_word = v[129:98]; src_hi_sel = v[97]; cnt_word = v[96:65];
        dst_old = v[64:33]; dst_hi_sel = v[32]; wr_en = we;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i], 1'b1);
            check($sformatf("table[%0d] R1/R2/R3/R4/R5/R6/R7/R8/R10", i), VEC[i][31:0]);
        end

        // R8: no write, different inputs, output must hold.
        held = dst_word;
        drive({32'hFFFF0000, 1'b1, 32'h00000000, 32'h00000000, 1'b1, 32'h0}, 1'b0);
        check("R8 hold without write", held);
        drive({32'h00001234, 1'b0, 32'h00000001, 32'h55555555, 1'b0, 32'h0}, 1'b0);
        check("R8 hold second cycle", held);

        // R5: same inputs, only operand half differs.
        drive({32'h00020004, 1'b1, 32'h00000001, 32'h00000000, 1'b0, 32'h0}, 1'b1);
        check("R5 upper operand", 32'h00000004);
        drive({32'h00020004, 1'b0, 32'h00000001, 32'h00000000, 1'b0, 32'h0}, 1'b1);
        check("R5 lower operand", 32'h00000008);

        // R9: reset overrides write enable.
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1;
        src_word = 32'h0000FFFF;
        cnt_word = 32'h0;
        @(posedge clk);
        #1;
        check("R9 reset over write", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R9 stays clear after reset", 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule